// File: doc/BRIEF.md
# Banked Interrupt Vector Controller

This block gathers a wide set of interrupt vector inputs into banks of 32 and turns them into one parent interrupt line per bank. A pulse on any vector input latches a pending bit, which stays set until software acknowledges it. Each bank also has a word of enable bits. The parent line of a bank is raised while any of its pending bits is also enabled.

Software uses a simple single-cycle register bus. It reads a pending word to see which vectors fired, whether or not they are enabled. It acknowledges vectors by writing ones to the pending word. It masks or unmasks vectors through a read-modify-write of the enable word. The number of banks is a parameter from one to eight. Bank slots past that count read as zero, and writes to them are dropped.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every pending bit, every enable bit, every parent line and the read data are 0.
- R2: Vector n maps to bank n/32, bit n mod 32. A vector input that is high during a clock edge sets that pending bit, and the bit stays set through any number of idle cycles until it is acknowledged.
- R3: A read at byte offset 4*i (i below the bank count) returns the raw pending word of bank i, whatever the state of its enable bits.
- R4: A write to byte offset 4*i clears each pending bit of bank i whose write-data bit is 1 and leaves bits written with 0 unchanged. Writing 0xFFFFFFFF clears the whole bank.
- R5: Byte offset 0x20 + 4*i holds the enable word of bank i. A write replaces the whole word, a read returns it, and enable bit 1 means unmasked.
- R6: Parent line i is high exactly one clock after the cycle in which bank i holds at least one bit that is both pending and enabled.
- R7: When a vector event and an acknowledge of the same pending bit fall in the same cycle, the bit ends up set.
- R8: Reads of offsets that map to no implemented register (banks at or past the bank count, or offsets 0x40 and above) return 0, and writes to them change no state.
- R9: Read data appears on the read-data port in the cycle after the read request and is 0 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_in | input | NUM_BANKS*32 | Vector event inputs, one bit per vector |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word-aligned byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| parent_irq | output | NUM_BANKS | Parent interrupt line for each bank |

## Verification
A new vector event and a software acknowledge of the same pending bit can land on one clock edge. The bench forces this by pulsing a vector input in the same cycle as a write-one-to-clear whose data covers that bit and a second, already pending bit. It expects the colliding bit to read back as set and the other bit to read back as cleared. The parent line for that bank must stay high throughout.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int REG_W     = 32;
    localparam int MAX_BANKS = 8;
    localparam int EN_BIT    = 5;   // offset bit 5 picks the enable region
    localparam int REGION_SH = 6;   // offsets at or above 0x40 are unmapped

    typedef struct packed {
        logic [REG_W-1:0] pend;
        logic [REG_W-1:0] en;
        logic             irq;
    } bank_state_t;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } rd_state_t;
endpackage

// File: rtl/irqv_bus_decode.sv
module irqv_bus_decode
    import irqv_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_BANKS-1:0] pend_wr,
    output logic [NUM_BANKS-1:0] en_wr,
    output logic [NUM_BANKS-1:0] pend_rd,
    output logic [NUM_BANKS-1:0] en_rd,
    output logic                 rd_stb
);
    localparam int IDX_W = 3;

    logic             in_region;
    logic             is_en;
    logic [IDX_W-1:0] idx;
    logic             wr_stb;

    always_comb begin
        in_region = ((bus_addr >> REGION_SH) == '0);
        is_en     = bus_addr[EN_BIT];
        idx       = bus_addr[IDX_W+1:2];
        wr_stb    = bus_valid && bus_write;
        rd_stb    = bus_valid && !bus_write;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        logic hit;
        always_comb begin
            hit        = in_region && (idx == IDX_W'(b));
            pend_wr[b] = wr_stb && hit && !is_en;
            en_wr[b]   = wr_stb && hit && is_en;
            pend_rd[b] = rd_stb && hit && !is_en;
            en_rd[b]   = rd_stb && hit && is_en;
        end
    end
endmodule

// File: rtl/irqv_bank.sv
module irqv_bank
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic             clr_we,
    input  logic             en_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] pend_q,
    output logic [REG_W-1:0] en_q,
    output logic             irq_q
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // acknowledge first, then let a new event win
        if (clr_we) begin
            st_d.pend = st_q.pend & ~wdata;
        end
        st_d.pend = st_d.pend | evt;
        if (en_we) begin
            st_d.en = wdata;
        end
        st_d.irq = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign en_q   = st_q.en;
    assign irq_q  = st_q.irq;

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R5
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_q == $past(wdata)));

    // R5
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(en_q));

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & en_q) == '0) |=> !irq_q);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((evt & wdata) != '0)) |=> ((pend_q & $past(evt & wdata)) == $past(evt & wdata)));
endmodule

// File: rtl/irqv_rdmux.sv
module irqv_rdmux
    import irqv_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_stb,
    input  logic [NUM_BANKS-1:0]       pend_rd,
    input  logic [NUM_BANKS-1:0]       en_rd,
    input  logic [NUM_BANKS*REG_W-1:0] pend_all,
    input  logic [NUM_BANKS*REG_W-1:0] en_all,
    output logic [REG_W-1:0]           rdata
);
    rd_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (pend_rd[b]) st_d.rdata = st_d.rdata | pend_all[b*REG_W +: REG_W];
            if (en_rd[b])   st_d.rdata = st_d.rdata | en_all[b*REG_W +: REG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    // R9
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (rdata == '0));

    // R8
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (pend_rd == '0) && (en_rd == '0)) |=> (rdata == '0));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*REG_W-1:0] vec_in,
    input  logic                       bus_valid,
    input  logic                       bus_write,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    output logic [NUM_BANKS-1:0]       parent_irq
);
    localparam int NUM_VEC = NUM_BANKS * REG_W;

    logic [NUM_BANKS-1:0] pend_wr, en_wr, pend_rd, en_rd;
    logic                 rd_stb;
    logic [NUM_VEC-1:0]   pend_all, en_all;

    irqv_bus_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .pend_wr   (pend_wr),
        .en_wr     (en_wr),
        .pend_rd   (pend_rd),
        .en_rd     (en_rd),
        .rd_stb    (rd_stb)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqv_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (vec_in[b*REG_W +: REG_W]),
            .clr_we (pend_wr[b]),
            .en_we  (en_wr[b]),
            .wdata  (bus_wdata),
            .pend_q (pend_all[b*REG_W +: REG_W]),
            .en_q   (en_all[b*REG_W +: REG_W]),
            .irq_q  (parent_irq[b])
        );
    end

    irqv_rdmux #(.NUM_BANKS(NUM_BANKS)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .pend_rd  (pend_rd),
        .en_rd    (en_rd),
        .pend_all (pend_all),
        .en_all   (en_all),
        .rdata    (bus_rdata)
    );

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_wr, en_wr, pend_rd, en_rd}));

    // R8
    no_wr_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_wr == '0) && (pend_wr == '0) && (vec_in == '0)) |=> ($stable(en_all) && $stable(pend_all)));
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb_top;
    localparam int NB = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NB*32-1:0] vec_in = '0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NB-1:0]    parent_irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pend [NB];
    logic [31:0] m_en   [NB];

    logic [31:0] q_val [$];
    string       q_tag [$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_in     (vec_in),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .parent_irq (parent_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] exp_parent();
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) p[b] = |(m_pend[b] & m_en[b]);
        return p;
    endfunction

    // monitor: compare read data against the scoreboard queue
    always @(posedge clk) rd_seen <= rst_n && bus_valid && !bus_write;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (q_val.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: actual %h expected no read data", bus_rdata);
            end else begin
                check(q_tag.pop_front(), bus_rdata, q_val.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (a < 8'h18) m_pend[a[4:2]] &= ~d;
        else if (a >= 8'h20 && a < 8'h38) m_en[a[4:2]] = d;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        q_val.push_back(exp); q_tag.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse(input int n);
        vec_in[n] = 1'b1;
        @(negedge clk);
        vec_in[n] = 1'b0;
        m_pend[n/32][n%32] = 1'b1;
    endtask

    task automatic settle_parent(input string tag);
        @(negedge clk);
        check(tag, 32'(parent_irq), 32'(exp_parent()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] tmp;
        for (int b = 0; b < NB; b++) begin m_pend[b] = '0; m_en[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 parent", 32'(parent_irq), 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        for (int b = 0; b < NB; b++) begin
            bus_rd(8'(4*b), 32'h0, "R1 pending");
            bus_rd(8'(8'h20 + 4*b), 32'h0, "R1 enable");
        end

        // R5 enable write and readback
        bus_wr(8'h20, 32'h0000_0005);
        bus_rd(8'h20, 32'h0000_0005, "R5 enable readback");

        // R2 R6 vector 0 into bank 0, enabled
        pulse(0);
        bus_rd(8'h00, 32'h0000_0001, "R2 bank0 pending");
        settle_parent("R6 parent bank0 up");

        // R3 vector 37 into masked bank 1
        pulse(37);
        bus_rd(8'h04, 32'h0000_0020, "R3 raw pending while masked");
        settle_parent("R6 parent bank1 masked");

        // R5 read-modify-write unmask of vector 37
        tmp = m_en[1] | 32'h0000_0020;
        bus_rd(8'h24, m_en[1], "R5 enable before rmw");
        bus_wr(8'h24, tmp);
        bus_rd(8'h24, 32'h0000_0020, "R5 enable after rmw");
        settle_parent("R6 parent bank1 unmasked");

        // R2 simultaneous events in separate banks
        vec_in[191] = 1'b1; vec_in[100] = 1'b1; vec_in[101] = 1'b1;
        @(negedge clk);
        vec_in = '0;
        m_pend[5][31] = 1'b1; m_pend[3][4] = 1'b1; m_pend[3][5] = 1'b1;
        repeat (20) @(negedge clk);
        bus_rd(8'h14, 32'h8000_0000, "R2 vector 191 held");
        bus_rd(8'h0C, 32'h0000_0030, "R2 vectors 100 101 held");
        bus_wr(8'h34, 32'h8000_0000);
        settle_parent("R6 parent bank5 up");

        // R4 write-one-to-clear
        bus_wr(8'h04, 32'h0000_0000);
        bus_rd(8'h04, 32'h0000_0020, "R4 zero write keeps");
        bus_wr(8'h0C, 32'h0000_0010);
        bus_rd(8'h0C, 32'h0000_0020, "R4 clear one bit");
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        bus_rd(8'h0C, 32'h0000_0000, "R4 clear whole bank");
        bus_wr(8'h00, 32'h0000_0001);
        settle_parent("R6 parent bank0 down");

        // R7 event and clear of the same bit in one cycle
        pulse(66);
        bus_wr(8'h28, 32'h0000_0006);
        vec_in[65] = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0000_0006;
        @(negedge clk);
        vec_in = '0; bus_valid = 1'b0; bus_write = 1'b0;
        m_pend[2] = 32'h0000_0002;
        bus_rd(8'h08, 32'h0000_0002, "R7 set wins over clear");
        check("R7 parent bank2 stays", 32'(parent_irq[2]), 32'h1);

        // R8 unmapped offsets
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'h38, 32'hFFFF_FFFF);
        bus_wr(8'h40, 32'hFFFF_FFFF);
        bus_rd(8'h18, 32'h0, "R8 pending past bank count");
        bus_rd(8'h38, 32'h0, "R8 enable past bank count");
        bus_rd(8'h44, 32'h0, "R8 offset above map");
        for (int b = 0; b < NB; b++) begin
            bus_rd(8'(4*b), m_pend[b], "R8 pending untouched");
            bus_rd(8'(8'h20 + 4*b), m_en[b], "R8 enable untouched");
        end

        // R9 idle read data
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);
        settle_parent("R6 final parents");

        repeat (2) @(negedge clk);
        if (q_val.size() != 0) begin
            checks++; fails++;
            $display("FAIL R9: actual %0d pending reads expected 0", q_val.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule